// File: doc/BRIEF.md
# Four-Phase I2C Bit Timing Generator

This block paces the bits of an I2C controller. A programmable divider turns the system clock into a base tick. Every bit on the bus is cut into four phases, and each phase lasts its own programmable number of base ticks. The phases are, in order: data setup with the clock line low, clock high before the data sample, clock high after the sample, and clock low with data hold.

At the last cycle of each phase the generator raises a one-cycle boundary pulse. While that pulse is high, the phase index output still names the phase that is ending. The sequencer that drives the bus uses the pulse and the index to decide when to change SDA, release SCL, sample SDA and pull SCL low. A separate pulse marks the end of a whole bit. The generator does no byte framing and decodes no instructions.

The timing inputs are meant to be changed only while the generator is held in restart or is disabled. The sequencer then enables it to run bits. A 24 MHz clock gives these bus rates: divider 1 with steps 5/5/5/11 gives about 1 MHz, divider 1 with steps 15/12/12/21 gives about 400 kHz, and divider 10 with steps 9/6/5/4 gives about 100 kHz.

Top module: `i2c_bit_timer`

## Requirements
- R1: While reset is asserted and after it is released, with enable low, `phase_o` is 0 and `tick_o`, `edge_o` and `bit_end_o` are 0.
- R2: While enable is high and restart is low, `tick_o` is high in one cycle out of every N, where N is `clk_div_i`. The first tick comes N cycles after a restart. A divider value of 0 acts as 1, so the tick is then high in every cycle.
- R3: Phase p (0 to 3) lasts S_p ticks, where S_p is field `steps_i[p*STEP_W +: STEP_W]`. A step value of 0 acts as 1. `phase_o` does not change on any tick that is not the last tick of the current phase.
- R4: `edge_o` is high only in the cycle that carries the last tick of a phase, and `phase_o` still shows the ending phase in that cycle. In the next cycle `phase_o` equals the ending phase plus 1, modulo 4, so the phases run in the order 0, 1, 2, 3.
- R5: `bit_end_o` is high exactly when `edge_o` is high and `phase_o` is 3. After it, `phase_o` returns to 0.
- R6: A cycle with `restart_i` high clears the divider count, the phase count and the phase index, so the next cycle starts phase 0 from its beginning. Restart takes priority over enable.
- R7: While `enable_i` is low, `tick_o`, `edge_o` and `bit_end_o` stay 0 and all counts hold. When enable returns, timing resumes exactly where it paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run the timing when high, freeze it when low |
| restart_i | input | 1 | Synchronous clear of all counts back to the start of phase 0 |
| clk_div_i | input | DIV_W | Base tick divider, 0 treated as 1 |
| steps_i | input | 4*STEP_W | Four phase lengths in ticks, phase p at bits p*STEP_W upward, 0 treated as 1 |
| tick_o | output | 1 | Base tick strobe |
| edge_o | output | 1 | Phase boundary pulse, high in the last cycle of a phase |
| phase_o | output | 2 | Index of the phase in progress |
| bit_end_o | output | 1 | High in the last cycle of phase 3 |

## Verification
All four outputs come from combinational logic fed by registers. A restart or an enable change at one clock edge therefore shows up on the outputs in the cycle that follows it, and a change of enable gates the tick in the same cycle. The bench changes its inputs on the falling edge and settles briefly. It then compares every output against a model that takes the count of enabled cycles since the last restart and computes, from the divider and the four step values, which phase is running and whether that cycle is a tick, a boundary or a bit end. The model's cycle count advances only on cycles that had enable high, so pauses are checked cycle by cycle too.

// File: rtl/i2c_bit_timer_pkg.sv
package i2c_bit_timer_pkg;

  typedef enum logic [1:0] {
    PH_DATA_SETUP = 2'd0,
    PH_CLK_RISE   = 2'd1,
    PH_CLK_HOLD   = 2'd2,
    PH_DATA_HOLD  = 2'd3
  } bit_phase_e;

  localparam int unsigned NUM_PHASES = 4;

  function automatic bit_phase_e next_phase(bit_phase_e cur);
    return bit_phase_e'(cur + 2'd1);
  endfunction

endpackage

// File: rtl/i2c_tick_divider.sv
module i2c_tick_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] count_o
);

  function automatic logic [DIV_W-1:0] eff_div(logic [DIV_W-1:0] d);
    return (d == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : d;
  endfunction

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap    = (cnt_q >= eff_div(div_i) - 1'b1);
  assign tick_o  = enable_i & wrap;
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (enable_i)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  assert_idle_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> !tick_o);

  assert_div_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/i2c_phase_seq.sv
module i2c_phase_seq
  import i2c_bit_timer_pkg::*;
#(
  parameter int unsigned STEP_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick_i,
  input  logic                         restart_i,
  input  logic [NUM_PHASES*STEP_W-1:0] steps_i,
  output logic                         edge_o,
  output bit_phase_e                   phase_o,
  output logic [STEP_W-1:0]            count_o
);

  function automatic logic [STEP_W-1:0] eff_step(logic [STEP_W-1:0] s);
    return (s == '0) ? {{(STEP_W-1){1'b0}}, 1'b1} : s;
  endfunction

  logic [STEP_W-1:0] step_tab [NUM_PHASES];

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_step
    assign step_tab[p] = eff_step(steps_i[p*STEP_W +: STEP_W]);
  end

  bit_phase_e        phase_q;
  logic [STEP_W-1:0] cnt_q;
  logic              at_last;

  assign at_last = (cnt_q >= step_tab[phase_q] - 1'b1);
  assign edge_o  = tick_i & at_last;
  assign phase_o = phase_q;
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DATA_SETUP;
      cnt_q   <= '0;
    end else if (restart_i) begin
      phase_q <= PH_DATA_SETUP;
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (at_last) begin
        phase_q <= next_phase(phase_q);
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_edge_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && !restart_i) |=> (phase_q == next_phase($past(phase_q))));

  assert_mid_phase_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_o && !restart_i) |=> $stable(phase_q));

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bit_timer_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned STEP_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable_i,
  input  logic                         restart_i,
  input  logic [DIV_W-1:0]             clk_div_i,
  input  logic [NUM_PHASES*STEP_W-1:0] steps_i,
  output logic                         tick_o,
  output logic                         edge_o,
  output logic [1:0]                   phase_o,
  output logic                         bit_end_o
);

  logic              base_tick;
  logic              phase_edge;
  bit_phase_e        cur_phase;
  logic [DIV_W-1:0]  div_count;
  logic [STEP_W-1:0] step_count;

  i2c_tick_divider #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (enable_i),
    .restart_i (restart_i),
    .div_i     (clk_div_i),
    .tick_o    (base_tick),
    .count_o   (div_count)
  );

  i2c_phase_seq #(.STEP_W(STEP_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (base_tick),
    .restart_i (restart_i),
    .steps_i   (steps_i),
    .edge_o    (phase_edge),
    .phase_o   (cur_phase),
    .count_o   (step_count)
  );

  assign tick_o    = base_tick;
  assign edge_o    = phase_edge;
  assign phase_o   = cur_phase;
  assign bit_end_o = phase_edge && (cur_phase == PH_DATA_HOLD);

  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (div_count == '0 && step_count == '0 && cur_phase == PH_DATA_SETUP));

  assert_edge_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_edge |-> base_tick);

  assert_bit_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end_o && !restart_i) |=> (cur_phase == PH_DATA_SETUP));

  assert_idle_no_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> (!phase_edge && !bit_end_o));

endmodule

// File: tb/i2c_bit_timer_test.sv
module i2c_bit_timer_test;

  localparam int DIV_W  = 8;
  localparam int STEP_W = 6;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                enable_i = 1'b0;
  logic                restart_i = 1'b0;
  logic [DIV_W-1:0]    clk_div_i = '0;
  logic [4*STEP_W-1:0] steps_i = '0;
  logic                tick_o, edge_o, bit_end_o;
  logic [1:0]          phase_o;

  i2c_bit_timer #(.DIV_W(DIV_W), .STEP_W(STEP_W)) uut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .restart_i(restart_i),
    .clk_div_i(clk_div_i), .steps_i(steps_i), .tick_o(tick_o),
    .edge_o(edge_o), .phase_o(phase_o), .bit_end_o(bit_end_o));

  always #10 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int t = 0;
  int cfg_div = 1;
  int cfg_s [4];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, t);
    end
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic void model(int tt, output int tk, output int pu,
                                output int ph, output int be);
    int n, sum, r, tn, c;
    n = eff(cfg_div);
    sum = 0;
    for (int p = 0; p < 4; p++) sum += eff(cfg_s[p]);
    r  = tt % (n * sum);
    tk = ((tt % n) == n - 1) ? 1 : 0;
    tn = r / n;
    c  = 0;
    ph = 0; pu = 0;
    for (int p = 0; p < 4; p++) begin
      if (tn < c + eff(cfg_s[p])) begin
        ph = p;
        pu = (tk == 1 && tn == c + eff(cfg_s[p]) - 1) ? 1 : 0;
        break;
      end
      c += eff(cfg_s[p]);
    end
    be = (pu == 1 && ph == 3) ? 1 : 0;
  endfunction

  task automatic setup_and_restart(int d, int s0, int s1, int s2, int s3);
    @(negedge clk);
    cfg_div = d;
    cfg_s[0] = s0; cfg_s[1] = s1; cfg_s[2] = s2; cfg_s[3] = s3;
    clk_div_i = DIV_W'(d);
    steps_i = {STEP_W'(s3), STEP_W'(s2), STEP_W'(s1), STEP_W'(s0)};
    restart_i = 1'b1;
    enable_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
    t = 0;
  endtask

  // Already on a negedge after setup: each iteration checks one cycle.
  task automatic run(int n, int en_pct);
    int tk, pu, ph, be;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      enable_i = (($urandom % 100) < en_pct) ? 1'b1 : 1'b0;
      #1;
      model(t, tk, pu, ph, be);
      if (!enable_i) begin
        chk("R7 tick while paused", int'(tick_o), 0);
        chk("R7 edge while paused", int'(edge_o), 0);
        chk("R7 phase held", int'(phase_o), ph);
      end else begin
        chk("R2 tick", int'(tick_o), tk);
        chk("R3 phase", int'(phase_o), ph);
        chk("R4 edge", int'(edge_o), pu);
        chk("R5 bit_end", int'(bit_end_o), be);
        t++;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cfg_s[0] = 1; cfg_s[1] = 1; cfg_s[2] = 1; cfg_s[3] = 1;
    #35;
    #1;
    chk("R1 phase in reset", int'(phase_o), 0);
    chk("R1 edge in reset", int'(edge_o), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 phase after reset", int'(phase_o), 0);
    chk("R1 tick after reset", int'(tick_o), 0);
    chk("R1 bit_end after reset", int'(bit_end_o), 0);

    // R2/R3 presets for the three bus rates
    setup_and_restart(1, 5, 5, 5, 11);   run(60, 100);
    setup_and_restart(1, 15, 12, 12, 21); run(140, 100);
    setup_and_restart(10, 9, 6, 5, 4);   run(500, 100);

    // R2 and R3: zero divider and zero steps act as 1
    setup_and_restart(0, 0, 0, 0, 0);    run(12, 100);
    setup_and_restart(3, 0, 2, 0, 1);    run(40, 100);

    // R6: restart in the middle of a phase
    setup_and_restart(2, 4, 4, 4, 4);    run(13, 100);
    setup_and_restart(2, 4, 4, 4, 4);
    #1;
    chk("R6 phase after restart", int'(phase_o), 0);
    chk("R6 no tick right after restart", int'(tick_o), 0);
    run(40, 100);

    // R7: random pauses
    setup_and_restart(2, 3, 2, 2, 3);    run(200, 60);

    // Random configurations with random pauses
    for (int k = 0; k < 30; k++) begin
      setup_and_restart(int'($urandom % 6), int'($urandom % 8), int'($urandom % 8),
                        int'($urandom % 8), int'($urandom % 8));
      run(300, 75);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule